// File: doc/BRIEF.md
# QPSK Receive Dibit Correction and Serializer

This block closes the receive path of a four-phase demodulator. Two comparators slice the in-phase and quadrature detector outputs into sign bits. A sign bit of 1 stands for a positive detector output and 0 for a negative one. The recovered carrier can be locked at one of four quadrant offsets. An external controller, for example a preamble matcher, knows which offset applies and presents it on a two-bit select. The block undoes that rotation on each received dibit.

It then emits the corrected pair as a single serial stream at the bit rate. The channel-1 bit goes out first and the channel-2 bit second. The block runs on the bit-rate clock. An internal slot counter marks the first and second bit slot of every symbol. The channel inputs and the select are sampled only on the edge that opens a symbol. A synchronous clear realigns the slot counter, so the external symbol timing can be matched to it.

The constellation is Gray coded, with (d1,d2) = 11 at +45°, 10 at −45°, 01 at +135° and 00 at −135°. A +90° carrier offset therefore turns a sent pair (d1,d2) into the received pair (r1,r2) = (¬d2, d1).

Top module: `qpsk_dibit_serializer`

## Requirements
- R1: With `rot_sel` = 2'b00 (no offset), the bit driven on `ser_out` after the symbol-opening edge is `ch1_sign`, and after the following edge it is `ch2_sign`, both as sampled on the opening edge. A sign value of 1 means a positive detector output.
- R2: With `rot_sel` = 2'b10 (90° offset), the corrected pair is d1 = `ch2_sign` and d2 = ¬`ch1_sign`.
- R3: With `rot_sel` = 2'b01 (180° offset), the corrected pair is d1 = ¬`ch1_sign` and d2 = ¬`ch2_sign`.
- R4: With `rot_sel` = 2'b11 (270° offset), the corrected pair is d1 = ¬`ch2_sign` and d2 = `ch1_sign`.
- R5: Changes on `ch1_sign`, `ch2_sign` and `rot_sel` during the second bit slot of a symbol have no effect on the bit sent in that slot.
- R6: The bit slot alternates on every clock edge while `clr` is low, so each symbol yields exactly two output bits, d1 then d2. For any sent stream and any of the four offsets, applying the matching select restores the original stream.
- R7: `clr` high at a clock edge forces `ser_out` to 0 and makes the next edge a symbol-opening edge. This holds even if that edge would otherwise have loaded a symbol.
- R8: While `rst_n` is low, `ser_out` is 0. The first edge after release opens a symbol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous clear of slot phase and output |
| ch1_sign | input | 1 | Sliced channel-1 detector sign (1 = positive) |
| ch2_sign | input | 1 | Sliced channel-2 detector sign (1 = positive) |
| rot_sel | input | 2 | Carrier offset select: 00 = 0°, 10 = 90°, 01 = 180°, 11 = 270° |
| ser_out | output | 1 | Corrected serial data at the bit rate |

## Verification
Two events can meet on one edge: a symbol-opening load, and either a clear or a change of select and channel inputs. The bench provokes the first case by holding `clr` high across an edge where a symbol with a 1 in its first bit is presented. It expects 0 and then a clean realignment. It provokes the second case on every table vector by inverting the channel signs and the select during the second slot. That slot must still carry the d2 latched on the opening edge.

// File: rtl/qpsk_ser_pkg.sv
package qpsk_ser_pkg;

  localparam int DIBIT_BITS = 2;

  // Select decode: bit order matters, a neighbour drives it.
  typedef enum logic [1:0] {
    ROT_0   = 2'b00,
    ROT_180 = 2'b01,
    ROT_90  = 2'b10,
    ROT_270 = 2'b11
  } rot_sel_e;

  typedef struct packed {
    logic b1;
    logic b2;
  } dibit_t;

endpackage

// File: rtl/qpsk_dibit_fix.sv
module qpsk_dibit_fix
  import qpsk_ser_pkg::*;
(
  input  dibit_t   rx,
  input  rot_sel_e sel,
  output dibit_t   fixed
);

  // Undo a quadrant rotation of the Gray-coded constellation.
  always_comb begin
    unique case (sel)
      ROT_0:   fixed = rx;
      ROT_90:  fixed = '{b1: rx.b2,  b2: ~rx.b1};
      ROT_180: fixed = '{b1: ~rx.b1, b2: ~rx.b2};
      ROT_270: fixed = '{b1: ~rx.b2, b2: rx.b1};
      default: fixed = rx;
    endcase
  end

endmodule

// File: rtl/qpsk_slot_ctr.sv
module qpsk_slot_ctr #(
  parameter int SLOTS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic first_slot
);

  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic [SW-1:0] slot_q, slot_d;

  always_comb begin
    if (clr || slot_q == LAST) slot_d = '0;
    else                       slot_d = slot_q + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign first_slot = (slot_q == '0);

endmodule

// File: rtl/qpsk_p2s.sv
module qpsk_p2s #(
  parameter int SLOTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [SLOTS-1:0] word,
  output logic             ser_out
);

  logic             ser_q, ser_d;
  logic [SLOTS-1:0] rest_q, rest_d;

  // MSB of word leaves first; the remainder shifts up behind it.
  always_comb begin
    ser_d  = ser_q;
    rest_d = rest_q;
    if (clr) begin
      ser_d  = 1'b0;
      rest_d = '0;
    end else if (load) begin
      ser_d  = word[SLOTS-1];
      rest_d = {word[SLOTS-2:0], 1'b0};
    end else begin
      ser_d  = rest_q[SLOTS-1];
      rest_d = {rest_q[SLOTS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_q  <= 1'b0;
      rest_q <= '0;
    end else begin
      ser_q  <= ser_d;
      rest_q <= rest_d;
    end
  end

  assign ser_out = ser_q;

endmodule

// File: rtl/qpsk_dibit_serializer.sv
module qpsk_dibit_serializer
  import qpsk_ser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       ch1_sign,
  input  logic       ch2_sign,
  input  logic [1:0] rot_sel,
  output logic       ser_out
);

  localparam int SLOTS = DIBIT_BITS;

  logic   first_slot;
  logic   load;
  dibit_t rx_pair;
  dibit_t fixed_pair;

  assign rx_pair = '{b1: ch1_sign, b2: ch2_sign};

  qpsk_slot_ctr #(.SLOTS(SLOTS)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .first_slot (first_slot)
  );

  qpsk_dibit_fix u_fix (
    .rx    (rx_pair),
    .sel   (rot_sel_e'(rot_sel)),
    .fixed (fixed_pair)
  );

  assign load = first_slot && !clr;

  qpsk_p2s #(.SLOTS(SLOTS)) u_p2s (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .load    (load),
    .word    (fixed_pair),
    .ser_out (ser_out)
  );

endmodule

// File: rtl/qpsk_dibit_serializer_chk.sv
module qpsk_dibit_serializer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       ch1_sign,
  input logic       ch2_sign,
  input logic [1:0] rot_sel,
  input logic       ser_out,
  input logic       first_slot
);

  // R1
  pass_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && first_slot && rot_sel == 2'b00) |=> ser_out == $past(ch1_sign));

  // R2
  q90_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && first_slot && rot_sel == 2'b10) |=> ser_out == $past(ch2_sign));

  // R3
  q180_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && first_slot && rot_sel == 2'b01) |=> ser_out == !$past(ch1_sign));

  // R4
  q270_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && first_slot && rot_sel == 2'b11) |=> ser_out == !$past(ch2_sign));

  // R5
  second_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !first_slot && $past(rot_sel) == 2'b00) |=> ser_out == $past(ch2_sign, 2));

  // R6
  slot_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> first_slot != $past(first_slot));

  // R7
  clear_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!ser_out && first_slot));

  // R8
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (!ser_out && first_slot);
    end
  end

endmodule

bind qpsk_dibit_serializer qpsk_dibit_serializer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .ch1_sign   (ch1_sign),
  .ch2_sign   (ch2_sign),
  .rot_sel    (rot_sel),
  .ser_out    (ser_out),
  .first_slot (first_slot)
);

// File: tb/qpsk_dibit_serializer_test.sv
module qpsk_dibit_serializer_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr;
  logic       ch1_sign;
  logic       ch2_sign;
  logic [1:0] rot_sel;
  logic       ser_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  qpsk_dibit_serializer uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .ch1_sign (ch1_sign),
    .ch2_sign (ch2_sign),
    .rot_sel  (rot_sel),
    .ser_out  (ser_out)
  );

  // Each entry: {sent d1, sent d2, quadrant offset 0..3}
  localparam logic [3:0] VEC [12] = '{
    4'b11_00, 4'b10_00, 4'b01_01, 4'b00_01,
    4'b11_10, 4'b01_10, 4'b10_11, 4'b00_11,
    4'b11_01, 4'b10_10, 4'b01_11, 4'b00_00
  };

  // +90 deg rotation: (r1,r2) = (~d2, d1), applied q times
  function automatic logic [1:0] rotate(logic [1:0] d, int q);
    for (int k = 0; k < q; k++) d = {~d[0], d[1]};
    return d;
  endfunction

  function automatic logic [1:0] sel_for(int q);
    case (q)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  function automatic string req_for(int q);
    case (q)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(logic act, logic exp, string req, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Called at a negedge preceding a symbol-opening edge.
  task automatic send_sym(logic [1:0] sent, int q, bit scramble);
    logic [1:0] rx = rotate(sent, q);
    ch1_sign = rx[1];
    ch2_sign = rx[0];
    rot_sel  = sel_for(q);
    @(negedge clk);
    check(ser_out, sent[1], req_for(q), "first slot d1");
    if (scramble) begin
      ch1_sign = ~rx[1];
      ch2_sign = ~rx[0];
      rot_sel  = ~sel_for(q);
    end
    @(negedge clk);
    check(ser_out, sent[0], scramble ? "R5" : req_for(q), "second slot d2");
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; clr = 1'b0;
    ch1_sign = 1'b1; ch2_sign = 1'b1; rot_sel = 2'b00;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(ser_out, 1'b0, "R8", "output in reset");
    rst_n = 1'b1;

    // Table walk with second-slot scrambling (R1..R5)
    foreach (VEC[i]) send_sym(VEC[i][3:2], int'(VEC[i][1:0]), 1'b1);

    // Random stream under every quadrant (R6)
    for (int n = 0; n < 40; n++) begin
      logic [1:0] d = 2'($urandom);
      send_sym(d, n % 4, 1'b0);
    end

    // Clear mid-symbol, then clear over a loading edge (R7)
    ch1_sign = 1'b1; ch2_sign = 1'b1; rot_sel = 2'b00;
    @(negedge clk);
    check(ser_out, 1'b1, "R1", "pre-clear d1");
    clr = 1'b1;
    @(negedge clk);
    check(ser_out, 1'b0, "R7", "clear mid-symbol");
    @(negedge clk);
    check(ser_out, 1'b0, "R7", "clear over load edge");
    clr = 1'b0;
    send_sym(2'b10, 0, 1'b0);
    send_sym(2'b01, 2, 1'b1);

    // Reset in mid-stream, then realignment (R8)
    ch1_sign = 1'b1; ch2_sign = 1'b0; rot_sel = 2'b00;
    @(negedge clk);
    rst_n = 1'b0;
    #1 check(ser_out, 1'b0, "R8", "async reset output");
    @(negedge clk);
    rst_n = 1'b1;
    send_sym(2'b11, 3, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule